// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block models a small parallel NOR flash array behind a synchronous byte-wide bus slave. Plain reads return stored bytes. Writes are not stored directly. They are decoded as bus cycles of a command protocol: two unlock writes at fixed word offsets, then a command byte. The command selects one of several modes: identifier read, query-table read, program, sector erase, chip erase, or a bypass mode that drops the unlock cycles for later commands.

Programming can only clear bits. While a program command waits for its data, and for the whole of an erase, reads return a status byte instead of array data. Bit 6 of the status byte toggles on every such read, which lets software poll for progress. The two erase durations are parameters in clock cycles, and a `busy` output is high for the whole erase. Command offsets are decoded from address bits [10:0]. The array is split into equal sectors of 2^SECT_AW bytes.

Top module: `nor_cmd_seq`

## Requirements
- R1: While reset is low and straight after reset, `busy` is 0 and `rd_data` is 0x00. After reset the block is in array-read mode with status 0x00.
- R2: An unlock sequence is 0xAA at offset 0x555, then 0x55 at offset 0x2AA, then a command at offset 0x555. A write with the wrong data or the wrong offset at any step returns the block to array-read mode and starts no command.
- R3: After command 0x90 the block is in identifier mode. In that mode, read offsets (address bits [7:0]) 0x00 and 0x01 return the two ID parameters, 0x02 returns 0x00, and 0x0E/0x0F return the two extended IDs when EXT_ID_EN is set. Every other offset reads the array.
- R4: Data 0x98 at offset 0x055 enters query mode, either from array-read mode or from identifier mode. In query mode, index (address bits [7:0]) 0x10..0x12 reads "QRY", 0x13 reads 0x02, 0x27 reads ADDR_W, 0x2C reads 0x01, 0x2D/0x2E read the sector count minus one, and 0x2F/0x30 read the sector size divided by 256. Other indices below 0x31 read 0x00, and every index of 0x31 or more reads 0x00. Any write leaves query mode for array-read mode.
- R5: After command 0xA0, the next write ANDs its data into the addressed byte. The status byte then becomes 0x7F if data bit 7 was 1 and 0xFF if it was 0. The block returns to array-read mode, or to the command step if bypass is on.
- R6: While a program command waits for its data, reads return the status byte and bit 6 toggles after each read. A data byte of 0xF0 is programmed as data.
- R7: Outside a pending program and outside an erase, a write of 0xF0 at any address returns the block to array-read mode and turns bypass off.
- R8: Command 0x80 followed by a second unlock pair and 0x30 at any address sets every byte of the addressed sector to 0xFF. Other sectors are left unchanged. The status byte is cleared and `busy` is high for SECT_CYC cycles.
- R9: Command 0x80 followed by a second unlock pair and 0x10 at offset 0x555 sets every byte to 0xFF, clears status and holds `busy` for CHIP_CYC cycles. A 0x10 at any other offset aborts and erases nothing.
- R10: While `busy` is high, all writes are ignored and reads return the status byte with bit 6 toggling after each read. When the erase ends, status bit 7 inverts and the block goes to array-read mode, or to the command step if bypass is on.
- R11: Command 0x20 turns bypass on. In bypass, each command is one write at any offset, with no unlock cycles, and a finished program returns to the command step. 0x90 followed by 0x00 turns bypass off and returns to array-read mode.
- R12: A command byte other than 0x20, 0x80, 0x90 or 0xA0 aborts to array-read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address of the read or write |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_data | input | 8 | Write data or command byte |
| rd_en | input | 1 | Read strobe; `rd_data` is updated on the next edge |
| rd_data | output | 8 | Registered read data, held between reads |
| busy | output | 1 | High for the whole duration of an erase |

## Verification
The bound checker watches, on every cycle, the relations between sequencer state and status:
- bypass is always off in array-read mode;
- `busy` is low in reset and stays high until the timer ends;
- an erase start clears status, and the timer end flips status bit 7;
- the status byte after a program is set from the data written;
- 0xF0 resets the mode and turns bypass off;
- the bypass exit works.

Only the bench scenarios can show the stored contents: AND-only programming, an erase confined to one sector, and the array left untouched by aborted or ignored writes. The same holds for the ID and query values and for the bit-6 toggle sequence seen over successive status reads.

// File: rtl/nor_pkg.sv
package nor_pkg;
  // Offset decode is taken from the low address bits
  localparam int CMD_AW = 11;

  localparam logic [CMD_AW-1:0] OFF_CMD = 11'h555;
  localparam logic [CMD_AW-1:0] OFF_ACK = 11'h2AA;
  localparam logic [CMD_AW-1:0] OFF_QRY = 11'h055;

  localparam logic [7:0] D_UNLK0 = 8'hAA;
  localparam logic [7:0] D_UNLK1 = 8'h55;
  localparam logic [7:0] D_BYP   = 8'h20;
  localparam logic [7:0] D_ESET  = 8'h80;
  localparam logic [7:0] D_IDM   = 8'h90;
  localparam logic [7:0] D_PROG  = 8'hA0;
  localparam logic [7:0] D_QRY   = 8'h98;
  localparam logic [7:0] D_RST   = 8'hF0;
  localparam logic [7:0] D_CHIP  = 8'h10;
  localparam logic [7:0] D_SECT  = 8'h30;
  localparam logic [7:0] D_BEXIT = 8'h00;

  localparam logic [7:0] QRY_LEN = 8'h31;

  typedef enum logic [3:0] {
    ST_ARRAY, // plain array read
    ST_UNLK1, // first unlock seen
    ST_CMD,   // awaiting command byte
    ST_PROG,  // awaiting program data
    ST_EU0,   // erase setup, awaiting second unlock pair
    ST_EU1,
    ST_ECMD,  // awaiting erase kind
    ST_BUSY,  // erase timer running
    ST_ID,    // identifier read
    ST_QRY    // query table read
  } seq_state_e;
endpackage

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
  import nor_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic [CMD_AW-1:0] wr_off,
  input  logic              erase_done,
  output seq_state_e        state_q,
  output logic              bypass_q,
  output logic              prog_fire,
  output logic              chip_start,
  output logic              sect_start
);
  seq_state_e state_d;
  logic       bypass_d;
  logic       at_cmd, at_ack, qry_hit;

  assign at_cmd  = (wr_off == OFF_CMD);
  assign at_ack  = (wr_off == OFF_ACK);
  assign qry_hit = (wr_off == OFF_QRY) && (wr_data == D_QRY);

  assign prog_fire  = wr_en && (state_q == ST_PROG);
  assign chip_start = wr_en && (state_q == ST_ECMD) && (wr_data == D_CHIP) && at_cmd;
  assign sect_start = wr_en && (state_q == ST_ECMD) && (wr_data == D_SECT);

  always_comb begin
    state_d  = state_q;
    bypass_d = bypass_q;
    if (state_q == ST_BUSY) begin
      if (erase_done) state_d = bypass_q ? ST_CMD : ST_ARRAY;
    end else if (wr_en) begin
      // abort is the default outcome of every write
      state_d  = ST_ARRAY;
      bypass_d = 1'b0;
      if (!(wr_data == D_RST && state_q != ST_PROG)) begin
        unique case (state_q)
          ST_ARRAY, ST_EU0: begin
            if (qry_hit) begin
              state_d  = ST_QRY;
              bypass_d = bypass_q;
            end else if (at_cmd && wr_data == D_UNLK0) begin
              state_d  = (state_q == ST_ARRAY) ? ST_UNLK1 : ST_EU1;
              bypass_d = bypass_q;
            end
          end
          ST_UNLK1, ST_EU1: begin
            if (at_ack && wr_data == D_UNLK1) begin
              state_d  = (state_q == ST_UNLK1) ? ST_CMD : ST_ECMD;
              bypass_d = bypass_q;
            end
          end
          ST_CMD: begin
            if (bypass_q || at_cmd) begin
              bypass_d = bypass_q;
              unique case (wr_data)
                D_BYP:   begin state_d = ST_CMD; bypass_d = 1'b1; end
                D_ESET:  state_d = ST_EU0;
                D_IDM:   state_d = ST_ID;
                D_PROG:  state_d = ST_PROG;
                default: begin state_d = ST_ARRAY; bypass_d = 1'b0; end
              endcase
            end
          end
          ST_PROG: begin
            state_d  = bypass_q ? ST_CMD : ST_ARRAY;
            bypass_d = bypass_q;
          end
          ST_ECMD: begin
            if (chip_start || sect_start) begin
              state_d  = ST_BUSY;
              bypass_d = bypass_q;
            end
          end
          ST_ID: begin
            if (!(bypass_q && wr_data == D_BEXIT) && qry_hit) begin
              state_d  = ST_QRY;
              bypass_d = bypass_q;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_ARRAY;
      bypass_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      bypass_q <= bypass_d;
    end
  end
endmodule

// File: rtl/nor_erase_timer.sv
module nor_erase_timer #(
  parameter int CHIP_CYC = 240,
  parameter int SECT_CYC = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_start,
  input  logic sect_start,
  output logic erase_done
);
  localparam int MAXC = (CHIP_CYC > SECT_CYC) ? CHIP_CYC : SECT_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign erase_done = (cnt_q == CW'(1));

  always_comb begin
    cnt_en = chip_start || sect_start || (cnt_q != '0);
    if (chip_start)      cnt_d = CW'(CHIP_CYC);
    else if (sect_start) cnt_d = CW'(SECT_CYC);
    else                 cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/nor_flash_array.sv
module nor_flash_array #(
  parameter int ADDR_W  = 11,
  parameter int SECT_AW = 10
) (
  input  logic              clk,
  input  logic              prog_en,
  input  logic              chip_clr,
  input  logic              sect_clr,
  input  logic [ADDR_W-1:0] wa,
  input  logic [7:0]        wd,
  input  logic [ADDR_W-1:0] ra,
  output logic [7:0]        rd
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [7:0] mem [DEPTH];
  int         wsect;

  assign wsect = int'(wa >> SECT_AW);
  assign rd    = mem[ra];

  // storage has no reset; contents are defined by erase
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (chip_clr || (sect_clr && ((i >> SECT_AW) == wsect)))
        mem[i] <= 8'hFF;
    end
    if (prog_en) mem[wa] <= mem[wa] & wd;
  end
endmodule

// File: rtl/nor_qry_rom.sv
module nor_qry_rom
  import nor_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int SECT_AW = 10
) (
  input  logic [7:0] idx,
  output logic [7:0] val
);
  localparam int NSECT_M1 = (2 ** (ADDR_W - SECT_AW)) - 1;
  localparam int SECT_B   = 2 ** SECT_AW;
  localparam logic [7:0] V_SIZE = 8'(ADDR_W);
  localparam logic [7:0] V_NS0  = 8'(NSECT_M1);
  localparam logic [7:0] V_NS1  = 8'(NSECT_M1 >> 8);
  localparam logic [7:0] V_SZ0  = 8'(SECT_B >> 8);
  localparam logic [7:0] V_SZ1  = 8'(SECT_B >> 16);

  always_comb begin
    val = 8'h00;
    if (idx < QRY_LEN) begin
      unique case (idx)
        8'h10:   val = 8'h51;
        8'h11:   val = 8'h52;
        8'h12:   val = 8'h59;
        8'h13:   val = 8'h02;
        8'h27:   val = V_SIZE;
        8'h2C:   val = 8'h01;
        8'h2D:   val = V_NS0;
        8'h2E:   val = V_NS1;
        8'h2F:   val = V_SZ0;
        8'h30:   val = V_SZ1;
        default: val = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_pkg::*;
#(
  parameter int         ADDR_W    = 11,
  parameter int         SECT_AW   = 10,
  parameter int         CHIP_CYC  = 240,
  parameter int         SECT_CYC  = 60,
  parameter logic [7:0] ID_MFR    = 8'h01,
  parameter logic [7:0] ID_DEV    = 8'h7E,
  parameter bit         EXT_ID_EN = 1'b1,
  parameter logic [7:0] ID_EXT0   = 8'h22,
  parameter logic [7:0] ID_EXT1   = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  output logic [7:0]        rd_data,
  output logic              busy
);
  seq_state_e state_q;
  logic       bypass_q, prog_fire, chip_start, sect_start, erase_done;
  logic [7:0] arr_rd, qry_val, rd_d, rd_q, status_q, status_d;
  logic       stat_rd;

  nor_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_off(addr[CMD_AW-1:0]), .erase_done(erase_done),
    .state_q(state_q), .bypass_q(bypass_q), .prog_fire(prog_fire),
    .chip_start(chip_start), .sect_start(sect_start)
  );

  nor_erase_timer #(.CHIP_CYC(CHIP_CYC), .SECT_CYC(SECT_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .chip_start(chip_start),
    .sect_start(sect_start), .erase_done(erase_done)
  );

  nor_flash_array #(.ADDR_W(ADDR_W), .SECT_AW(SECT_AW)) u_arr (
    .clk(clk), .prog_en(prog_fire), .chip_clr(chip_start),
    .sect_clr(sect_start), .wa(addr), .wd(wr_data), .ra(addr), .rd(arr_rd)
  );

  nor_qry_rom #(.ADDR_W(ADDR_W), .SECT_AW(SECT_AW)) u_qry (
    .idx(addr[7:0]), .val(qry_val)
  );

  assign stat_rd = (state_q == ST_PROG) || (state_q == ST_BUSY);
  assign busy    = (state_q == ST_BUSY);
  assign rd_data = rd_q;

  // read source selection
  always_comb begin
    rd_d = arr_rd;
    if (stat_rd) begin
      rd_d = status_q;
    end else if (state_q == ST_QRY) begin
      rd_d = qry_val;
    end else if (state_q == ST_ID) begin
      unique case (addr[7:0])
        8'h00:   rd_d = ID_MFR;
        8'h01:   rd_d = ID_DEV;
        8'h02:   rd_d = 8'h00;
        8'h0E:   rd_d = EXT_ID_EN ? ID_EXT0 : arr_rd;
        8'h0F:   rd_d = EXT_ID_EN ? ID_EXT1 : arr_rd;
        default: rd_d = arr_rd;
      endcase
    end
  end

  // status byte next value
  always_comb begin
    status_d = status_q;
    if (rd_en && stat_rd)           status_d[6] = ~status_q[6];
    if (prog_fire)                  status_d = {~wr_data[7], 7'h7F};
    if (chip_start || sect_start)   status_d = 8'h00;
    if (erase_done)                 status_d[7] = ~status_d[7];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q     <= 8'h00;
      status_q <= 8'h00;
    end else begin
      if (rd_en) rd_q <= rd_d;
      status_q <= status_d;
    end
  end
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk
  import nor_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       busy,
  input seq_state_e state_q,
  input logic       bypass_q,
  input logic [7:0] status_q,
  input logic       erase_done,
  input logic       prog_fire
);
  assert_idle_in_reset_R1: assert property (@(posedge clk)
    !rst_n |-> !busy);

  assert_prog_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    prog_fire |=> (status_q[6:0] == 7'h7F) && (status_q[7] != $past(wr_data[7])));

  assert_prog_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
    prog_fire && !bypass_q |=> state_q == ST_ARRAY);

  assert_f0_resets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data == D_RST && state_q != ST_PROG && state_q != ST_BUSY
    |=> state_q == ST_ARRAY && !bypass_q);

  assert_erase_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> status_q == 8'h00);

  assert_busy_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !erase_done |=> busy);

  assert_done_flips_R10: assert property (@(posedge clk) disable iff (!rst_n)
    erase_done |=> status_q[7] != $past(status_q[7]));

  assert_bypass_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_q && state_q == ST_ID && wr_en && wr_data == D_BEXIT
    |=> !bypass_q && state_q == ST_ARRAY);

  assert_array_no_bypass_R11: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_ARRAY |-> !bypass_q);
endmodule

bind nor_cmd_seq nor_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .busy(busy),
  .state_q(state_q), .bypass_q(bypass_q), .status_q(status_q),
  .erase_done(erase_done), .prog_fire(prog_fire)
);

// File: tb/sim_nor_cmd_seq.sv
module sim_nor_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 11;
  localparam int SAW  = 10;
  localparam int CHIP = 240;
  localparam int SECT = 60;
  localparam logic [7:0] MFR = 8'h01, DEV = 8'h7E, EX0 = 8'h22, EX1 = 8'h01;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]    wr_data = '0;
  logic [7:0]    rd_data;
  logic          busy;

  nor_cmd_seq #(.ADDR_W(AW), .SECT_AW(SAW), .CHIP_CYC(CHIP), .SECT_CYC(SECT),
    .ID_MFR(MFR), .ID_DEV(DEV), .EXT_ID_EN(1'b1), .ID_EXT0(EX0), .ID_EXT1(EX1)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .busy(busy));

  always #(CLK_PERIOD/2) clk = ~clk;

  int    total = 0, fails = 0;
  bit    finished = 0;
  string cur_tag = "R1";

  // behavioural reference model
  // modes: 0 read,1 unlock1,2 command,3 program pending,4/5 erase unlocks,
  //        6 erase kind,7 erasing,8 identifier,9 query
  logic [7:0] m_mem [2**AW];
  bit         m_known [2**AW];
  int         m_st = 0, m_cnt = 0;
  bit         m_byp = 0;
  logic [7:0] m_stat = 0;
  logic [7:0] exp_rd;
  bit         exp_ok, chk_rd = 0;
  string      rd_tag;

  function automatic logic [7:0] qry(input logic [7:0] i);
    if (i >= 8'h31) return 8'h00;
    case (i)
      8'h10: return "Q";
      8'h11: return "R";
      8'h12: return "Y";
      8'h13: return 8'h02;
      8'h27: return 8'(AW);
      8'h2C: return 8'h01;
      8'h2D: return 8'((1 << (AW - SAW)) - 1);
      8'h2F: return 8'((1 << SAW) >> 8);
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_abort();
    m_st = 0; m_byp = 0;
  endtask

  task automatic model_write(input logic [AW-1:0] a, input logic [7:0] d);
    logic [10:0] o;
    o = a[10:0];
    if (d == 8'hF0 && m_st != 3) begin model_abort(); return; end
    case (m_st)
      0, 4: if (o == 11'h055 && d == 8'h98) m_st = 9;
            else if (o == 11'h555 && d == 8'hAA) m_st = (m_st == 0) ? 1 : 5;
            else model_abort();
      1, 5: if (o == 11'h2AA && d == 8'h55) m_st = (m_st == 1) ? 2 : 6;
            else model_abort();
      2: if (!m_byp && o != 11'h555) model_abort();
         else if (d == 8'h20) m_byp = 1;
         else if (d == 8'h80) m_st = 4;
         else if (d == 8'h90) m_st = 8;
         else if (d == 8'hA0) m_st = 3;
         else model_abort();
      3: begin
        m_mem[a] = m_mem[a] & d;
        m_stat = d[7] ? 8'h7F : 8'hFF;
        m_st = m_byp ? 2 : 0;
      end
      6: if (d == 8'h10 && o == 11'h555) begin
           for (int i = 0; i < 2**AW; i++) begin m_mem[i] = 8'hFF; m_known[i] = 1; end
           m_stat = 0; m_cnt = CHIP; m_st = 7;
         end else if (d == 8'h30) begin
           for (int i = 0; i < 2**AW; i++)
             if ((i >> SAW) == int'(a >> SAW)) begin m_mem[i] = 8'hFF; m_known[i] = 1; end
           m_stat = 0; m_cnt = SECT; m_st = 7;
         end else model_abort();
      8: if (!(m_byp && d == 8'h00) && o == 11'h055 && d == 8'h98) m_st = 9;
         else model_abort();
      default: model_abort();
    endcase
  endtask

  always @(posedge clk) begin
    int pre;
    if (!rst_n) begin
      m_st = 0; m_byp = 0; m_stat = 0; m_cnt = 0; chk_rd = 0;
    end else begin
      pre = m_st;
      if (rd_en) begin
        chk_rd = 1; rd_tag = cur_tag; exp_ok = 1;
        if (pre == 3 || pre == 7) begin exp_rd = m_stat; m_stat[6] = ~m_stat[6]; end
        else if (pre == 9) exp_rd = qry(addr[7:0]);
        else if (pre == 8 && addr[7:0] == 8'h00) exp_rd = MFR;
        else if (pre == 8 && addr[7:0] == 8'h01) exp_rd = DEV;
        else if (pre == 8 && addr[7:0] == 8'h02) exp_rd = 8'h00;
        else if (pre == 8 && addr[7:0] == 8'h0E) exp_rd = EX0;
        else if (pre == 8 && addr[7:0] == 8'h0F) exp_rd = EX1;
        else begin exp_rd = m_mem[addr]; exp_ok = m_known[addr]; end
      end
      if (pre == 7) begin
        m_cnt--;
        if (m_cnt == 0) begin m_st = m_byp ? 2 : 0; m_stat[7] = ~m_stat[7]; end
      end else if (wr_en) begin
        model_write(addr, wr_data);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [7:0] act,
                       input logic [7:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // comparison against the model on every falling edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(busy === (m_st == 7), "R10 busy flag", {7'b0, busy}, {7'b0, m_st == 7});
      if (chk_rd) begin
        chk_rd = 0;
        if (exp_ok) check(rd_data === exp_rd, rd_tag, rd_data, exp_rd);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    cur_tag = tag; addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic unlock();
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55);
  endtask

  task automatic cmd(input logic [7:0] c);
    unlock(); wr(11'h555, c);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 2**AW; i++) begin m_known[i] = 0; m_mem[i] = 0; end
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R1 busy in reset", {7'b0, busy}, 8'h00);
    check(rd_data === 8'h00, "R1 rd_data in reset", rd_data, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_data === 8'h00, "R1 rd_data after reset", rd_data, 8'h00);

    // identifier mode
    cmd(8'h90);
    rd(11'h000, "R3 id0"); rd(11'h001, "R3 id1"); rd(11'h002, "R3 prot");
    rd(11'h00E, "R3 ext0"); rd(11'h00F, "R3 ext1");
    wr(11'h000, 8'hF0);

    // query mode from read mode and from identifier mode
    wr(11'h055, 8'h98);
    rd(11'h010, "R4 Q"); rd(11'h011, "R4 R"); rd(11'h012, "R4 Y");
    rd(11'h013, "R4 set"); rd(11'h027, "R4 size"); rd(11'h02D, "R4 nsect");
    rd(11'h02F, "R4 sectsz"); rd(11'h040, "R4 beyond");
    wr(11'h000, 8'h00);
    cmd(8'h90); wr(11'h055, 8'h98); rd(11'h010, "R4 from id");
    wr(11'h123, 8'h77);

    // chip erase with writes ignored and status polling while busy
    cmd(8'h80); unlock(); wr(11'h555, 8'h10);
    rd(11'h000, "R10 status poll a"); rd(11'h000, "R10 status poll b");
    wr(11'h555, 8'hAA); wr(11'h000, 8'hF0); wr(11'h010, 8'h00);
    rd(11'h010, "R10 status poll c");
    idle(CHIP);
    rd(11'h000, "R9 erased lo"); rd(11'h7FF, "R9 erased hi"); rd(11'h010, "R10 write ignored");

    // program, AND behaviour, pending-program status
    cmd(8'hA0); wr(11'h123, 8'h5A); rd(11'h123, "R5 program");
    cmd(8'hA0); wr(11'h123, 8'h0F); rd(11'h123, "R5 and-only");
    cmd(8'hA0); rd(11'h100, "R6 pending status a"); rd(11'h100, "R6 pending status b");
    wr(11'h100, 8'hF0); rd(11'h100, "R6 f0 as data");
    cmd(8'hA0); rd(11'h100, "R5 status after program");
    wr(11'h100, 8'h70);

    // aborted sequences
    wr(11'h555, 8'hAA); wr(11'h2AB, 8'h55); wr(11'h555, 8'hA0); wr(11'h123, 8'h00);
    rd(11'h123, "R2 bad second offset");
    unlock(); wr(11'h554, 8'hA0); wr(11'h123, 8'h00);
    rd(11'h123, "R2 bad command offset");
    cmd(8'h77); wr(11'h123, 8'h00); rd(11'h123, "R12 unknown command");

    // sector erase leaves the other sector alone
    cmd(8'hA0); wr(11'h400, 8'h00);
    cmd(8'hA0); wr(11'h010, 8'h11);
    cmd(8'h80); unlock(); wr(11'h456, 8'h30);
    rd(11'h456, "R8 status during sector erase");
    idle(SECT);
    rd(11'h400, "R8 sector erased"); rd(11'h7FF, "R8 sector erased end");
    rd(11'h010, "R8 other sector kept");
    cmd(8'h80); unlock(); wr(11'h554, 8'h10);
    rd(11'h010, "R9 bad chip offset");

    // bypass mode
    cmd(8'h20);
    wr(11'h7AB, 8'hA0); wr(11'h300, 8'h3C); rd(11'h300, "R11 bypass program");
    wr(11'h001, 8'hA0); wr(11'h301, 8'h0C); rd(11'h301, "R11 back to command");
    wr(11'h001, 8'h90); rd(11'h000, "R11 bypass id");
    wr(11'h000, 8'h00); rd(11'h000, "R11 exit bypass");
    wr(11'h7AB, 8'hA0); wr(11'h300, 8'h00); rd(11'h300, "R11 no bypass after exit");
    cmd(8'h20); wr(11'h000, 8'hF0);
    wr(11'h300, 8'hA0); wr(11'h300, 8'h00); rd(11'h300, "R7 f0 clears bypass");
    cmd(8'h20); wr(11'h7AB, 8'h80); unlock(); wr(11'h222, 8'h30);
    idle(SECT);
    wr(11'h222, 8'hA0); wr(11'h222, 8'h44); rd(11'h222, "R10 erase returns to bypass");
    rd(11'h300, "R8 bypass sector erase");
    wr(11'h000, 8'hF0);

    idle(2);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule